// File: doc/BRIEF.md
# Register-File ALU Datapath

This block is the execute stage of a small 16-bit processor. It holds eight general-purpose registers and four condition flags: negative, zero, overflow and carry. It takes an operation that has already been decoded into an operation code and three register indices. It reads the operands and runs them through an adder, logic unit or shifter. It then writes the result back and updates the flags on the same clock edge. Arithmetic and logic operations take two sources and a separate destination. The two shifts are dyadic: the destination register is also the value that gets shifted, and a second register gives the shift amount.

Register 0 is a sink. It always reads as zero, and any result aimed at it is dropped while the flags still update. Software can therefore compare or test two values without spending a register. A separate load port lets the surrounding pipeline place data (for example a memory read) into a register. A peek port reads any register without side effects.

Top module: `exec_datapath`

## Requirements
- R1: On a clock edge with `ld_en` high, register `ld_idx` takes `ld_data`. `peek_data` always shows the current content of register `peek_idx`.
- R2: Register 0 reads as zero on every read port. Writes to index 0 from either port are discarded.
- R3: An operation whose destination is index 0 writes no register but still updates all four flags from its result.
- R4: After every executed operation, flag_n equals bit 15 of the result and flag_z is set exactly when the 16-bit result is zero.
- R5: Op code 0 (add with carry) gives RS1 + RS2 + flag_c. It sets C to the carry out of bit 15 and V on two's-complement overflow.
- R6: Op code 1 (subtract) gives RS1 - RS2. It sets C when a borrow occurs and V on two's-complement overflow.
- R7: Op codes 2, 3 and 4 give RS1 AND, OR and XOR RS2. They clear V and leave C unchanged.
- R8: Op codes 5 (shift left) and 6 (shift right, zero fill) shift register RD by the full 16-bit value of register RS2 and write the result to RD; the RS1 index is ignored. An amount of 16 or more gives zero. C takes the last bit shifted out, which is 0 for amounts above 16. C is unchanged for an amount of zero. V is cleared.
- R9: Registers and flags change only on an edge with `op_valid` high. Op code 7 is reserved and changes neither registers nor flags.
- R10: When an operation and a load target the same register on the same edge, the operation's result is kept.
- R11: After reset every register and every flag is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid | input | 1 | Execute the presented operation on this edge |
| op_code | input | 3 | Decoded operation code |
| rd_idx | input | 3 | Destination index (also the shifted operand for shifts) |
| rs1_idx | input | 3 | First source index |
| rs2_idx | input | 3 | Second source index or shift-amount register |
| ld_en | input | 1 | Load port write enable |
| ld_idx | input | 3 | Load port register index |
| ld_data | input | 16 | Load port data |
| peek_idx | input | 3 | Observation read index |
| peek_data | output | 16 | Content of register peek_idx |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_v | output | 1 | Overflow flag |
| flag_c | output | 1 | Carry / borrow flag |

## Verification
A corrupted register or a misrouted write index shows on the peek port as soon as the following cycle, when the affected register is read. It also spreads into every later result that uses that register. A wrong carry value stays hidden until the next add with carry or zero-amount shift, which is why the bench sets the carry explicitly before every vector. Flag faults show one edge after the operation, and the bench checks all four flags after every executed operation.

// File: rtl/exec_pkg.sv
package exec_pkg;
    typedef enum logic [2:0] {
        OP_ADC  = 3'd0,
        OP_SUB  = 3'd1,
        OP_AND  = 3'd2,
        OP_OR   = 3'd3,
        OP_XOR  = 3'd4,
        OP_SHL  = 3'd5,
        OP_SHR  = 3'd6,
        OP_RSVD = 3'd7
    } alu_op_e;

    function automatic logic is_shift(input alu_op_e op);
        return (op == OP_SHL) || (op == OP_SHR);
    endfunction

    function automatic logic is_logic(input alu_op_e op);
        return (op == OP_AND) || (op == OP_OR) || (op == OP_XOR);
    endfunction
endpackage

// File: rtl/exec_regbank.sv
module exec_regbank #(
    parameter int DATA_W  = 16,
    parameter int REG_CNT = 8,
    localparam int IDX_W  = $clog2(REG_CNT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ex_we,
    input  logic [IDX_W-1:0]  ex_idx,
    input  logic [DATA_W-1:0] ex_data,
    input  logic              ld_we,
    input  logic [IDX_W-1:0]  ld_idx,
    input  logic [DATA_W-1:0] ld_data,
    input  logic [IDX_W-1:0]  ra_idx,
    output logic [DATA_W-1:0] ra_data,
    input  logic [IDX_W-1:0]  rb_idx,
    output logic [DATA_W-1:0] rb_data,
    input  logic [IDX_W-1:0]  rp_idx,
    output logic [DATA_W-1:0] rp_data
);
    logic [DATA_W-1:0] regs [REG_CNT];

    for (genvar g = 0; g < REG_CNT; g++) begin : g_reg
        if (g == 0) begin : g_sink
            assign regs[g] = '0;
        end else begin : g_store
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    regs[g] <= '0;
                end else if (ex_we && ex_idx == IDX_W'(g)) begin
                    regs[g] <= ex_data;
                end else if (ld_we && ld_idx == IDX_W'(g)) begin
                    regs[g] <= ld_data;
                end
            end
        end
    end

    assign ra_data = regs[ra_idx];
    assign rb_data = regs[rb_idx];
    assign rp_data = regs[rp_idx];

    a_r2_sink_read: assert property (@(posedge clk) disable iff (!rst_n)
        (rp_idx == '0) |-> (rp_data == '0));
endmodule

// File: rtl/exec_alu.sv
module exec_alu
    import exec_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  alu_op_e           op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              cin,
    output logic [DATA_W-1:0] res,
    output logic              n_o,
    output logic              z_o,
    output logic              v_o,
    output logic              c_o,
    output logic              legal
);
    localparam int MSB = DATA_W - 1;

    logic [DATA_W:0] sum_w, dif_w, shl_w, shr_w;

    always_comb begin
        sum_w = {1'b0, a} + {1'b0, b} + {{DATA_W{1'b0}}, cin};
        dif_w = {1'b0, a} - {1'b0, b};
        shl_w = {1'b0, a} << b;
        shr_w = {a, 1'b0} >> b;
        res   = '0;
        v_o   = 1'b0;
        c_o   = cin;
        legal = 1'b1;
        unique case (op)
            OP_ADC: begin
                res = sum_w[MSB:0];
                c_o = sum_w[DATA_W];
                v_o = (a[MSB] == b[MSB]) && (res[MSB] != a[MSB]);
            end
            OP_SUB: begin
                res = dif_w[MSB:0];
                c_o = dif_w[DATA_W];
                v_o = (a[MSB] != b[MSB]) && (res[MSB] != a[MSB]);
            end
            OP_AND: res = a & b;
            OP_OR:  res = a | b;
            OP_XOR: res = a ^ b;
            OP_SHL: begin
                res = shl_w[MSB:0];
                if (b != '0) c_o = shl_w[DATA_W];
            end
            OP_SHR: begin
                res = shr_w[DATA_W:1];
                if (b != '0) c_o = shr_w[0];
            end
            OP_RSVD: legal = 1'b0;
        endcase
        n_o = res[MSB];
        z_o = (res == '0);
    end
endmodule

// File: rtl/exec_datapath.sv
module exec_datapath
    import exec_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int REG_CNT = 8,
    localparam int IDX_W  = $clog2(REG_CNT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [2:0]        op_code,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic [IDX_W-1:0]  rs1_idx,
    input  logic [IDX_W-1:0]  rs2_idx,
    input  logic              ld_en,
    input  logic [IDX_W-1:0]  ld_idx,
    input  logic [DATA_W-1:0] ld_data,
    input  logic [IDX_W-1:0]  peek_idx,
    output logic [DATA_W-1:0] peek_data,
    output logic              flag_n,
    output logic              flag_z,
    output logic              flag_v,
    output logic              flag_c
);
    alu_op_e           op;
    logic [IDX_W-1:0]  a_idx;
    logic [DATA_W-1:0] opa, opb, alu_res;
    logic              nx, zx, vx, cx, legal, commit;

    assign op     = alu_op_e'(op_code);
    assign a_idx  = is_shift(op) ? rd_idx : rs1_idx;
    assign commit = op_valid && legal;

    exec_regbank #(.DATA_W(DATA_W), .REG_CNT(REG_CNT)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .ex_we   (commit && rd_idx != '0),
        .ex_idx  (rd_idx),
        .ex_data (alu_res),
        .ld_we   (ld_en),
        .ld_idx  (ld_idx),
        .ld_data (ld_data),
        .ra_idx  (a_idx),
        .ra_data (opa),
        .rb_idx  (rs2_idx),
        .rb_data (opb),
        .rp_idx  (peek_idx),
        .rp_data (peek_data)
    );

    exec_alu #(.DATA_W(DATA_W)) u_alu (
        .op    (op),
        .a     (opa),
        .b     (opb),
        .cin   (flag_c),
        .res   (alu_res),
        .n_o   (nx),
        .z_o   (zx),
        .v_o   (vx),
        .c_o   (cx),
        .legal (legal)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            {flag_n, flag_z, flag_v, flag_c} <= 4'b0000;
        end else if (commit) begin
            {flag_n, flag_z, flag_v, flag_c} <= {nx, zx, vx, cx};
        end
    end

    a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> $stable({flag_n, flag_z, flag_v, flag_c}));
    a_r9_reserved_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op == OP_RSVD) |=> $stable({flag_n, flag_z, flag_v, flag_c}));
    a_r4_neg_follows: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> (flag_n == $past(alu_res[DATA_W-1])));
    a_r8_zero_amt_keep: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && is_shift(op) && opb == '0) |=> (flag_c == $past(flag_c)));
    a_r7_logic_clear_v: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && is_logic(op)) |=> !flag_v);
endmodule

// File: tb/exec_datapath_bench.sv
`timescale 1ns/1ps
module exec_datapath_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [2:0]  op_code = '0, rd_idx = '0, rs1_idx = '0, rs2_idx = '0;
    logic        ld_en = 1'b0;
    logic [2:0]  ld_idx = '0, peek_idx = '0;
    logic [15:0] ld_data = '0, peek_data;
    logic        flag_n, flag_z, flag_v, flag_c;
    int          total = 0, bad = 0;

    always #4 clk = ~clk;

    exec_datapath u_exec_datapath (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .rd_idx(rd_idx), .rs1_idx(rs1_idx), .rs2_idx(rs2_idx),
        .ld_en(ld_en), .ld_idx(ld_idx), .ld_data(ld_data),
        .peek_idx(peek_idx), .peek_data(peek_data),
        .flag_n(flag_n), .flag_z(flag_z), .flag_v(flag_v), .flag_c(flag_c)
    );

    // {op, a, b, carry_in, result, NZVC}
    localparam int NV = 15;
    localparam logic [55:0] VEC [NV] = '{
        {3'd0, 16'h1234, 16'h0001, 1'b0, 16'h1235, 4'b0000}, // R5
        {3'd0, 16'hFFFF, 16'h0000, 1'b1, 16'h0000, 4'b0101}, // R5 carry in
        {3'd0, 16'h7FFF, 16'h0001, 1'b0, 16'h8000, 4'b1010}, // R5 overflow
        {3'd1, 16'h0005, 16'h0007, 1'b0, 16'hFFFE, 4'b1001}, // R6 borrow
        {3'd1, 16'h8000, 16'h0001, 1'b0, 16'h7FFF, 4'b0010}, // R6 overflow
        {3'd1, 16'h4444, 16'h4444, 1'b1, 16'h0000, 4'b0100}, // R6 equal
        {3'd2, 16'hF0F0, 16'h3C3C, 1'b1, 16'h3030, 4'b0001}, // R7 and
        {3'd3, 16'h8001, 16'h0100, 1'b0, 16'h8101, 4'b1000}, // R7 or
        {3'd4, 16'hAAAA, 16'hAAAA, 1'b1, 16'h0000, 4'b0101}, // R7 xor
        {3'd5, 16'h8001, 16'h0001, 1'b0, 16'h0002, 4'b0001}, // R8 shl 1
        {3'd5, 16'h1234, 16'h0000, 1'b1, 16'h1234, 4'b0001}, // R8 amount 0
        {3'd6, 16'h0003, 16'h0001, 1'b0, 16'h0001, 4'b0001}, // R8 shr 1
        {3'd6, 16'h8000, 16'h0010, 1'b0, 16'h0000, 4'b0101}, // R8 amount 16
        {3'd5, 16'hFFFF, 16'h0014, 1'b1, 16'h0000, 4'b0100}, // R8 amount 20
        {3'd6, 16'h1238, 16'h0004, 1'b0, 16'h0123, 4'b0001}  // R8 shr 4
    };

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic load(input logic [2:0] idx, input logic [15:0] d);
        @(negedge clk);
        ld_en = 1'b1; ld_idx = idx; ld_data = d;
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    task automatic exec(input logic v, input logic [2:0] op, input logic [2:0] rd,
                        input logic [2:0] s1, input logic [2:0] s2);
        @(negedge clk);
        op_valid = v; op_code = op; rd_idx = rd; rs1_idx = s1; rs2_idx = s2;
        @(negedge clk);
        op_valid = 1'b0;
    endtask

    function automatic logic [15:0] flags();
        return {12'd0, flag_n, flag_z, flag_v, flag_c};
    endfunction

    task automatic peek(input logic [2:0] idx, output logic [15:0] d);
        peek_idx = idx;
        #1;
        d = peek_data;
    endtask

    task automatic set_carry(input logic c);
        if (c) begin
            load(3'd7, 16'h0001);
            exec(1'b1, 3'd1, 3'd0, 3'd0, 3'd7);
        end else begin
            exec(1'b1, 3'd0, 3'd0, 3'd0, 3'd0);
        end
    endtask

    initial begin
        #(8 * 200000);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [15:0] d, fsave;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R11 reset state
        for (int i = 0; i < 8; i++) begin
            peek(3'(i), d);
            check("R11 reg after reset", d, 16'h0000);
        end
        check("R11 flags after reset", flags(), 16'h0000);

        for (int i = 0; i < NV; i++) begin
            logic [2:0]  op;
            logic [15:0] a, b, r;
            logic        ci;
            logic [3:0]  f;
            logic [2:0]  dst;
            {op, a, b, ci, r, f} = VEC[i];
            dst = (op >= 3'd5) ? 3'd1 : 3'd3;
            load(3'd1, a);
            load(3'd2, b);
            set_carry(ci);
            exec(1'b1, op, dst, 3'd1, 3'd2);
            peek(dst, d);
            check($sformatf("R4-R8 vec%0d result", i), d, r);
            check($sformatf("R4-R8 vec%0d flags", i), flags(), {12'd0, f});
        end

        // R1 load and peek; R2 load to R0 discarded
        load(3'd6, 16'hBEEF);
        peek(3'd6, d);
        check("R1 load port", d, 16'hBEEF);
        load(3'd0, 16'hFFFF);
        peek(3'd0, d);
        check("R2 write to R0 dropped", d, 16'h0000);

        // R2 source R0 reads zero
        load(3'd2, 16'h00AB);
        set_carry(1'b0);
        exec(1'b1, 3'd0, 3'd3, 3'd0, 3'd2);
        peek(3'd3, d);
        check("R2 R0 source is zero", d, 16'h00AB);

        // R3 destination R0: flags only
        load(3'd3, 16'h5A5A);
        load(3'd1, 16'h0005);
        load(3'd2, 16'h0005);
        set_carry(1'b1);
        exec(1'b1, 3'd1, 3'd0, 3'd1, 3'd2);
        check("R3 R0 dest flags", flags(), 16'h0004);
        peek(3'd0, d);
        check("R3 R0 stays zero", d, 16'h0000);
        peek(3'd3, d);
        check("R3 other reg untouched", d, 16'h5A5A);

        // R9 reserved op and invalid op change nothing
        fsave = flags();
        exec(1'b1, 3'd7, 3'd3, 3'd1, 3'd2);
        peek(3'd3, d);
        check("R9 reserved keeps reg", d, 16'h5A5A);
        check("R9 reserved keeps flags", flags(), fsave);
        exec(1'b0, 3'd4, 3'd3, 3'd1, 3'd0);
        peek(3'd3, d);
        check("R9 invalid keeps reg", d, 16'h5A5A);
        check("R9 invalid keeps flags", flags(), fsave);

        // R10 collision: ALU write wins (5 + 5 + C=0)
        @(negedge clk);
        ld_en = 1'b1; ld_idx = 3'd4; ld_data = 16'h1111;
        op_valid = 1'b1; op_code = 3'd0; rd_idx = 3'd4; rs1_idx = 3'd1; rs2_idx = 3'd2;
        @(negedge clk);
        ld_en = 1'b0; op_valid = 1'b0;
        peek(3'd4, d);
        check("R10 ALU beats load", d, 16'h000A);

        // R6 aliasing: R5 = R5 - R5
        load(3'd5, 16'h1234);
        exec(1'b1, 3'd1, 3'd5, 3'd5, 3'd5);
        peek(3'd5, d);
        check("R6 aliased subtract", d, 16'h0000);
        check("R4 aliased zero flag", flags(), 16'h0004);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule